// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside a small processor core and decides which interrupt the core services next. It latches a rising edge on each interrupt request line into a pending flag. It gates every pending flag with that source's own enable bit and with the core's global interrupt-enable bit, and picks the winner by fixed priority. It then issues a one-cycle take strobe with the program-memory vector address of the winner and a one-hot acknowledge. The take strobe tells the core to clear its global interrupt-enable bit. The acknowledged source's pending flag is cleared in the same cycle.

A separate reset request outranks every interrupt source. It ignores all enables, produces a strobe to vector 0, and wipes every pending flag. The controller is built around a three-state machine:
- `ST_READY`: the block may accept an interrupt.
- `ST_WAIT_CLR`: an interrupt was accepted, and the block waits to see the global enable go low before it can accept another.
- `ST_RESET`: a reset request is being held.

The transitions are:
- READY→WAIT_CLR on an accepted interrupt.
- WAIT_CLR→READY when the global enable is seen low.
- Any state→RESET while a reset request is present.
- RESET→READY once the request is released.

The source count is a parameter, meant to be 4 or 5.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Source k (index 0 upward) is served at vector address k+1. The reset request is served at vector 0. `vec_o` is 0 and `ack_o` is all zeros in any cycle without a take strobe.
- R2: Among eligible sources, the lowest index (lowest vector address) always wins.
- R3: A pending source is taken only when its bit of `src_en` is 1 and `gie` is 1. With `gie` at 0, no interrupt is taken whatever the enables are.
- R4: A pending flag is set by a 0→1 transition of its request line, seen between two consecutive clock edges. A line held high sets it only once.
- R5: A pending flag that is masked stays set, and the interrupt is taken once its enable becomes 1.
- R6: A take raises exactly the winner's bit of `ack_o` for one cycle and clears only that source's pending flag. The other pending flags are untouched.
- R7: `take_o` lasts one cycle, and the core must clear its global enable in response. After an interrupt is taken, no further interrupt is taken until `gie` has been sampled low and then high again.
- R8: A reset request gives one take strobe with vector 0 and no acknowledge, regardless of `gie`, `src_en` or pending sources. It clears all pending flags, including edges arriving while it is held. No strobe is produced while it stays high.
- R9: After `rst_n` is released, the outputs are zero and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| reset_req | input | 1 | Reset request; served at vector 0 above all sources |
| irq_req | input | NUM_SRC | Interrupt request lines, rising-edge sensitive |
| src_en | input | NUM_SRC | Per-source enable bits |
| gie | input | 1 | Global interrupt enable from the core status register |
| take_o | output | 1 | One-cycle strobe: jump to `vec_o`, clear global enable |
| vec_o | output | VEC_W | Vector address of the taken request |
| ack_o | output | NUM_SRC | One-hot acknowledge of the taken source |

## Verification
The bench sweeps every request pattern for five sources against several enable masks, and drains the pending set one take at a time. A design with the priority chain reversed would serve the highest index first. One that cleared all flags on a take would lose the later vectors in the drain. One that dropped masked flags would miss the second drain, which runs after the mask opens.

Further cases cover the following:
- A request line held high. A level-sensitive latch would fire again after every take.
- `gie` left high after a take. A design that ignores the wait state would re-fire at once.
- A reset request arriving while a source is eligible, while a take is outstanding, and together with a new request edge. Here a wrong priority or incomplete clearing shows up as a nonzero vector or as a later spurious take.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic [1:0] {
        ST_READY    = 2'd0,
        ST_WAIT_CLR = 2'd1,
        ST_RESET    = 2'd2
    } ivc_state_e;

endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
    parameter int NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               clr_all,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] pend_o
);

    logic [NUM_SRC-1:0] req_d;
    logic [NUM_SRC-1:0] rise_w;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign rise_w[i] = irq_req[i] & ~req_d[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                req_d[i]  <= 1'b0;
                pend_o[i] <= 1'b0;
            end else begin
                req_d[i] <= irq_req[i];
                if (clr_all)
                    pend_o[i] <= 1'b0;
                else if (rise_w[i])
                    pend_o[i] <= 1'b1;
                else if (clr_mask[i])
                    pend_o[i] <= 1'b0;
            end
        end

        // R4
        edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_all && rise_w[i]) |=> pend_o[i]);
    end

    // R8
    clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (pend_o == '0));

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
    parameter int NUM_SRC = 5,
    parameter int VEC_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [NUM_SRC-1:0] grant,
    output logic [VEC_W-1:0]   vec,
    output logic               any
);

    logic [NUM_SRC:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
        assign grant[i]     = req[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | req[i];
    end

    assign any = blocked[NUM_SRC];

    always_comb begin
        vec = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i])
                vec = VEC_W'(i + 1);
        end
    end

endmodule

// File: rtl/irq_vector_fsm.sv
module irq_vector_fsm
    import irq_vec_pkg::*;
#(
    parameter int NUM_SRC = 5,
    parameter int VEC_W   = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reset_req,
    input  logic               gie,
    input  logic [NUM_SRC-1:0] grant,
    input  logic [VEC_W-1:0]   vec_in,
    input  logic               any,
    output logic               take_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic [NUM_SRC-1:0] ack_o,
    output logic               clr_all,
    output logic [NUM_SRC-1:0] clr_mask
);

    ivc_state_e state_q, state_d;
    logic       fire;
    logic       rst_entry;

    assign fire      = (state_q == ST_READY) && any && !reset_req;
    assign rst_entry = reset_req && (state_q != ST_RESET);
    assign clr_all   = reset_req;
    assign clr_mask  = fire ? grant : '0;

    always_comb begin
        state_d = state_q;
        if (reset_req) begin
            state_d = ST_RESET;
        end else begin
            unique case (state_q)
                ST_READY:    if (any)  state_d = ST_WAIT_CLR;
                ST_WAIT_CLR: if (!gie) state_d = ST_READY;
                ST_RESET:    state_d = ST_READY;
                default:     state_d = ST_READY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_READY;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_o <= 1'b0;
            vec_o  <= '0;
            ack_o  <= '0;
        end else begin
            take_o <= fire | rst_entry;
            vec_o  <= fire ? vec_in : '0;
            ack_o  <= fire ? grant  : '0;
        end
    end

    // R7
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !reset_req) |=> !take_o);

    // R7
    wait_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_CLR && gie && !reset_req) |=> (!take_o && state_q == ST_WAIT_CLR));

    // R8
    rst_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && state_q != ST_RESET) |=> (take_o && vec_o == '0 && ack_o == '0));

    // R8
    rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESET && reset_req) |=> !take_o);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter int NUM_SRC = 5,
    parameter int VEC_W   = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reset_req,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               gie,
    output logic               take_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic [NUM_SRC-1:0] ack_o
);

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] clr_mask;
    logic [VEC_W-1:0]   arb_vec;
    logic               arb_any;
    logic               clr_all;

    assign elig = pend & src_en & {NUM_SRC{gie}};

    irq_pending_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .clr_all  (clr_all),
        .clr_mask (clr_mask),
        .pend_o   (pend)
    );

    irq_prio_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_arb (
        .req   (elig),
        .grant (grant),
        .vec   (arb_vec),
        .any   (arb_any)
    );

    irq_vector_fsm #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .reset_req (reset_req),
        .gie       (gie),
        .grant     (grant),
        .vec_in    (arb_vec),
        .any       (arb_any),
        .take_o    (take_o),
        .vec_o     (vec_o),
        .ack_o     (ack_o),
        .clr_all   (clr_all),
        .clr_mask  (clr_mask)
    );

    // R2
    prio_low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (((grant - NUM_SRC'(1)) & elig) == '0));

    // R6
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));

    // R3
    gated_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && ack_o != '0) |-> ($past(gie) && (($past(src_en) & ack_o) != '0)));

    // R1
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && ack_o != '0) |-> (vec_o != '0 && vec_o <= VEC_W'(NUM_SRC)));

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (vec_o == '0 && ack_o == '0));

endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;

    localparam int N       = 5;
    localparam int VW      = 3;
    localparam int CLK_PER = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reset_req;
    logic [N-1:0]  irq_req;
    logic [N-1:0]  src_en;
    logic          gie;
    logic          take_o;
    logic [VW-1:0] vec_o;
    logic [N-1:0]  ack_o;

    int nchk = 0;
    int nerr = 0;
    bit reported = 0;

    always #(CLK_PER/2) clk = ~clk;

    irq_vector_ctrl #(.NUM_SRC(N)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reset_req (reset_req),
        .irq_req   (irq_req),
        .src_en    (src_en),
        .gie       (gie),
        .take_o    (take_o),
        .vec_o     (vec_o),
        .ack_o     (ack_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
        end
    endtask

    function automatic int lowest(input logic [N-1:0] b);
        for (int i = 0; i < N; i++)
            if (b[i]) return i;
        return -1;
    endfunction

    task automatic expect_out(input string req, input bit et, input int ev, input int ea);
        int act;
        int exp;
        act = {take_o, vec_o, ack_o};
        exp = (int'(et) << (VW + N)) | (ev << N) | ea;
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: take/vec/ack act=%0b/%0d/%b exp=%0b/%0d/%b",
                     req, take_o, vec_o, ack_o, et, ev, ea[N-1:0]);
        end
    endtask

    // reset request pulse: R8 strobe at vector 0, then back to ready
    task automatic do_reset_req();
        reset_req = 1'b1;
        tick();
        expect_out("R8 reset strobe", 1, 0, 0);
        reset_req = 1'b0;
        tick();
        expect_out("R8 after release", 0, 0, 0);
    endtask

    task automatic load(input logic [N-1:0] pat);
        irq_req = pat;
        tick();
        irq_req = '0;
        tick();
    endtask

    // drain eligible pending sources one take at a time
    task automatic drain(inout logic [N-1:0] rem, input logic [N-1:0] mask, input string tag);
        bit done;
        int k;
        done = 0;
        src_en = mask;
        while (!done) begin
            gie = 1'b1;
            tick();
            k = lowest(rem & mask);
            if (k < 0) begin
                expect_out({tag, " R3/R5 nothing eligible"}, 0, 0, 0);
                done = 1;
            end else begin
                expect_out({tag, " R1/R2/R6 take"}, 1, k + 1, 1 << k);
                rem[k] = 1'b0;
                tick();
                expect_out({tag, " R7 no retake with gie high"}, 0, 0, 0);
                gie = 1'b0;
                tick();
            end
        end
        gie = 1'b0;
    endtask

    initial begin
        logic [N-1:0] rem;
        logic [N-1:0] masks [3];
        masks[0] = 5'b11111;
        masks[1] = 5'b10101;
        masks[2] = 5'b01010;

        rst_n     = 1'b0;
        reset_req = 1'b0;
        irq_req   = '0;
        src_en    = '0;
        gie       = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R9 reset state
        expect_out("R9 reset state", 0, 0, 0);
        src_en = '1;
        gie    = 1'b1;
        tick();
        tick();
        expect_out("R9 nothing pending", 0, 0, 0);
        gie    = 1'b0;
        src_en = '0;

        // R8 bypasses enables; held request strobes only once
        reset_req = 1'b1;
        tick();
        expect_out("R8 strobe without enables", 1, 0, 0);
        tick();
        expect_out("R8 held no strobe", 0, 0, 0);
        tick();
        expect_out("R8 held no strobe", 0, 0, 0);
        reset_req = 1'b0;
        tick();
        expect_out("R8 release", 0, 0, 0);

        // sweep of patterns and masks
        for (int p = 0; p < (1 << N); p++) begin
            for (int m = 0; m < 3; m++) begin
                do_reset_req();
                src_en = '1;
                gie    = 1'b0;
                load(N'(p));
                expect_out("R3 gie low blocks", 0, 0, 0);
                rem = N'(p);
                drain(rem, masks[m], "sweep masked");
                if (m != 0)
                    drain(rem, '1, "sweep R5 unmask");
            end
        end

        // R7 gie must be seen low before the next take
        do_reset_req();
        load(5'b00011);
        src_en = '1;
        gie    = 1'b1;
        tick();
        expect_out("R7 first take", 1, 1, 1);
        repeat (3) begin
            tick();
            expect_out("R7 hold while gie high", 0, 0, 0);
        end
        gie = 1'b0;
        tick();
        expect_out("R7 gie low", 0, 0, 0);
        gie = 1'b1;
        tick();
        expect_out("R7 second take", 1, 2, 2);
        gie = 1'b0;
        tick();

        // R4 held level sets only once
        do_reset_req();
        irq_req = 5'b00100;
        tick();
        tick();
        rem = 5'b00100;
        drain(rem, '1, "R4 held line");
        irq_req = '0;
        tick();
        rem = '0;
        drain(rem, '1, "R4 after fall");
        load(5'b00100);
        rem = 5'b00100;
        drain(rem, '1, "R4 new edge");

        // R8 wins over eligible source in the same cycle
        do_reset_req();
        load(5'b00001);
        src_en    = '1;
        gie       = 1'b1;
        reset_req = 1'b1;
        tick();
        expect_out("R8 beats source", 1, 0, 0);
        reset_req = 1'b0;
        gie       = 1'b0;
        tick();
        rem = '0;
        drain(rem, '1, "R8 cleared");

        // R8 clears pending, including an edge during the request
        load(5'b11111);
        reset_req  = 1'b1;
        irq_req[1] = 1'b1;
        tick();
        expect_out("R8 strobe with edge", 1, 0, 0);
        irq_req   = '0;
        reset_req = 1'b0;
        tick();
        rem = '0;
        drain(rem, '1, "R8 all cleared");

        // R8 during an outstanding take
        load(5'b01001);
        src_en = '1;
        gie    = 1'b1;
        tick();
        expect_out("R8 pre take", 1, 1, 1);
        reset_req = 1'b1;
        tick();
        expect_out("R8 strobe in wait", 1, 0, 0);
        reset_req = 1'b0;
        gie       = 1'b0;
        tick();
        rem = '0;
        drain(rem, '1, "R8 wait cleared");

        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired act=running exp=finished");
        report();
        $finish;
    end

endmodule